// File: doc/BRIEF.md
# Audio Master and Bit Clock Divider Chain

This block turns a chosen audio source clock into a master clock and a bit clock for a serial audio port. It runs entirely on one fast core clock. Each source clock edge arrives as a one-cycle tick: one from the system clock, one from an external oscillator, and one per direction from the master-clock pin. The derived clocks leave the block in two forms. One is a one-cycle tick at each rising edge. The other is a level for downstream logic or a pad. There is one independent chain per direction (transmit and receive). Each chain has its own settings for source, prescaler, modulus, final divider and master-clock mode.

The master clock is the selected source divided by 2 × P × M. P is 1 or 8 and M is 1 to 256. The square wave is built by a half-period counter followed by a toggle. A pass-through mode skips every divider and gives a ratio of 1. In pin mode the master clock is taken from outside, and the internal dividers for it go unused. The bit clock is always the master clock divided by F, which is 1 to 16. For example, a bit clock of sample rate × slot width × 2 is reached by choosing P, M and F to suit. Divisor values are computed by software and arrive as static settings. They should be changed while reset is held. If a setting changes outside reset, that direction's counters restart from zero.

Top module: `aud_clkdiv_chain`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, every `mck_tick`, `mck_lvl`, `bclk_tick` and `bclk_lvl` output is 0, even when source ticks are present.
- R2: Divide mode (`cfg_mck_in`=0, `cfg_bypass`=0). Take P = 8 when `cfg_psc8`=1 and P = 1 otherwise, and M = `cfg_mod_m1`+1. `mck_lvl` is a square wave with a period of 2·P·M selected source ticks. It first rises on source tick number P·M after reset and falls on tick 2·P·M. `mck_tick` pulses one core cycle after the tick that raises `mck_lvl`.
- R3: `cfg_src_ext`=0 selects `sys_tick` and `cfg_src_ext`=1 selects `ext_tick`. Ticks on the line that is not selected have no effect.
- R4: Pass-through mode (`cfg_bypass`=1, `cfg_mck_in`=0). `mck_tick` pulses one core cycle after every selected source tick, whatever P and M are set to, and `mck_lvl` stays 0.
- R5: Pin mode (`cfg_mck_in`=1, which takes priority over `cfg_bypass`). `mck_tick` pulses one core cycle after every `mck_pin_tick` of that direction, and `sys_tick` and `ext_tick` are ignored.
- R6: Take F = `cfg_fin_m1`+1. `bclk_tick` pulses one core cycle after master ticks number 1, F+1, 2F+1 and so on, counted from reset or restart. It pulses at no other time.
- R7: `bclk_lvl` is updated one core cycle after each master tick and holds between master ticks. Within each group of F master ticks it is 1 for the first floor(F/2) ticks and 0 for the rest. When F = 1 it is 1 for every tick.
- R8: The F setting has no effect on the timing of `mck_tick` or `mck_lvl`.
- R9: A change of any setting of a direction outside reset clears that direction's outputs in the next cycle. Source ticks in that cycle are ignored, and counting then resumes exactly as it does after reset.
- R10: The two directions are independent. Ticks, settings and restarts of one direction do not alter the outputs of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; every tick input is sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| sys_tick | input | 1 | One-cycle pulse per system audio clock edge |
| ext_tick | input | 1 | One-cycle pulse per external oscillator edge |
| mck_pin_tick | input | NUM_DIR | Per-direction pulse per edge of the master clock coming in on the pin |
| cfg_mck_in | input | NUM_DIR | 1: master clock comes from the pin |
| cfg_bypass | input | NUM_DIR | 1: master clock equals the selected source (ratio 1) |
| cfg_src_ext | input | NUM_DIR | 0: system clock, 1: external oscillator |
| cfg_psc8 | input | NUM_DIR | Prescaler: 0 gives P=1, 1 gives P=8 |
| cfg_mod_m1 | input | NUM_DIR×MOD_W | Modulus divider minus one (M-1) |
| cfg_fin_m1 | input | NUM_DIR×FIN_W | Bit-clock divider minus one (F-1) |
| mck_tick | output | NUM_DIR | Pulse at each master-clock rising edge |
| mck_lvl | output | NUM_DIR | Master-clock square wave (divide mode only) |
| bclk_tick | output | NUM_DIR | Pulse at each bit-clock rising edge |
| bclk_lvl | output | NUM_DIR | Bit-clock level |

## Verification
The divide path is driven with back-to-back source ticks, ticks every second or third cycle, and sparse ticks. This separates a counter that counts core cycles from one that counts only selected ticks. Prescaler values of 1 and 8 with small and full-range moduli confirm that P and M multiply, rather than only one of them taking effect. The upper bound of 2048 source ticks per half period is reached in one run. Noise on the line that is not selected, on the pins, and on both source lines in pin mode shows whether each mode picks its own tick line. Odd, even and unit bit-clock ratios are paired with the same master setting, and a mid-count setting change on one direction while the other runs on separates a true restart from an outright failure and from crosstalk between directions.

// File: rtl/acd_pkg.sv
`timescale 1ns/1ps
// Shared types for the audio clock divider chain.
package acd_pkg;
    // Where the master clock of a direction comes from.
    typedef enum logic [1:0] {
        MCK_DIVIDE = 2'd0,  // divided down from the selected source
        MCK_PASS   = 2'd1,  // selected source passed straight through
        MCK_PIN    = 2'd2   // supplied from outside on the master-clock pin
    } mck_mode_e;
endpackage

// File: rtl/acd_src_select.sv
`timescale 1ns/1ps
// Source selection for one direction.
// Picks the tick line that drives the master-clock stage and decodes the mode.
// Assumes every tick input is a single-cycle pulse in the core clock domain.
module acd_src_select
    import acd_pkg::*;
(
    input  logic      sys_tick,
    input  logic      ext_tick,
    input  logic      pin_tick,
    input  logic      mck_in,
    input  logic      bypass,
    input  logic      src_ext,
    output logic      src_tick,
    output mck_mode_e mode
);

    // Mode decode: the pin takes priority over pass-through.
    always_comb begin
        if (mck_in)      mode = MCK_PIN;
        else if (bypass) mode = MCK_PASS;
        else             mode = MCK_DIVIDE;
    end

    // Tick routing: the pin in pin mode, otherwise the chosen source.
    always_comb begin
        if (mck_in)       src_tick = pin_tick;
        else if (src_ext) src_tick = ext_tick;
        else              src_tick = sys_tick;
    end

endmodule

// File: rtl/acd_cfg_watch.sv
`timescale 1ns/1ps
// Configuration watcher for one direction.
// Keeps a copy of the settings and raises restart for one cycle when a
// setting changes outside reset. During reset the copy just follows.
module acd_cfg_watch #(
    parameter int CFG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CFG_W-1:0] cfg,
    output logic             restart
);

    logic [CFG_W-1:0] cfg_q;

    // Snapshot of the settings, also loaded while reset is held.
    always_ff @(posedge clk) begin
        cfg_q <= cfg;
    end

    // Any difference from the snapshot outside reset restarts the chain.
    assign restart = rst_n && (cfg != cfg_q);

endmodule

// File: rtl/acd_mck_div.sv
`timescale 1ns/1ps
// Master-clock stage for one direction.
// Divide mode: a half-period counter of P*M source ticks drives a toggle,
// giving a 50% square wave of period 2*P*M. Pass and pin modes forward the
// tick unchanged. Outputs are registered, one core cycle after the tick.
// Assumes mode, psc8 and mod_m1 are static apart from a restart.
module acd_mck_div
    import acd_pkg::*;
#(
    parameter int PSC_HI = 8,
    parameter int MOD_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             src_tick,
    input  mck_mode_e        mode,
    input  logic             psc8,
    input  logic [MOD_W-1:0] mod_m1,
    output logic             mck_tick,
    output logic             mck_lvl
);

    localparam int HALF_W = $clog2(PSC_HI) + MOD_W + 1;

    logic [HALF_W-1:0] psc_val;
    logic [HALF_W-1:0] mod_val;
    logic [HALF_W-1:0] half_m1;
    logic [HALF_W-1:0] cnt;

    // Half period in source ticks, minus one: P*M-1.
    assign psc_val = psc8 ? HALF_W'(PSC_HI) : HALF_W'(1);
    assign mod_val = HALF_W'(mod_m1) + HALF_W'(1);
    assign half_m1 = psc_val * mod_val - HALF_W'(1);

    // Count source ticks, toggle the level at each half period, flag rises.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt      <= '0;
            mck_lvl  <= 1'b0;
            mck_tick <= 1'b0;
        end else if (mode == MCK_DIVIDE) begin
            mck_tick <= 1'b0;
            if (src_tick) begin
                if (cnt == half_m1) begin
                    cnt      <= '0;
                    mck_lvl  <= ~mck_lvl;
                    mck_tick <= ~mck_lvl;
                end else begin
                    cnt <= cnt + HALF_W'(1);
                end
            end
        end else begin
            cnt      <= '0;
            mck_lvl  <= 1'b0;
            mck_tick <= src_tick;
        end
    end

    // R2: in divide mode a master tick coincides with a fresh rising level.
    assert_rise_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MCK_DIVIDE && mck_tick) |-> (mck_lvl && !$past(mck_lvl)));

    // R4 and R5: outside divide mode every accepted tick reappears next cycle.
    assert_pass_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != MCK_DIVIDE && src_tick && !clr) |=> mck_tick);

    // R4: outside divide mode the level output stays low.
    assert_pass_level_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != MCK_DIVIDE && $past(mode != MCK_DIVIDE)) |-> !mck_lvl);

endmodule

// File: rtl/acd_bclk_div.sv
`timescale 1ns/1ps
// Bit-clock stage for one direction.
// Counts master ticks modulo F. The first tick of each group raises
// bclk_tick, and the level is high for floor(F/2) ticks (1 when F = 1).
// Outputs are registered, one core cycle after the master tick.
module acd_bclk_div #(
    parameter int FIN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             mck_tick,
    input  logic [FIN_W-1:0] fin_m1,
    output logic             bclk_tick,
    output logic             bclk_lvl
);

    logic [FIN_W-1:0] bcnt;
    logic [FIN_W:0]   high_n;

    // Number of master ticks with the level high in each bit period.
    assign high_n = (fin_m1 == '0) ? (FIN_W+1)'(1)
                                   : (({1'b0, fin_m1} + (FIN_W+1)'(1)) >> 1);

    // Step the position within the bit period on each master tick.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            bcnt      <= '0;
            bclk_tick <= 1'b0;
            bclk_lvl  <= 1'b0;
        end else begin
            bclk_tick <= 1'b0;
            if (mck_tick) begin
                bclk_tick <= (bcnt == '0);
                bclk_lvl  <= ({1'b0, bcnt} < high_n);
                bcnt      <= (bcnt == fin_m1) ? '0 : bcnt + FIN_W'(1);
            end
        end
    end

    // R6: a bit-clock edge only ever follows a master tick.
    assert_bclk_after_mck_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bclk_tick |-> $past(mck_tick));

    // R7: the level holds when no master tick and no restart came before.
    assert_bclk_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(mck_tick) && !$past(clr)) |-> $stable(bclk_lvl));

    // R7: the first master tick of a bit period always drives the level high.
    assert_tick_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bclk_tick |-> bclk_lvl);

    // R9: a restart leaves both bit-clock outputs low.
    assert_restart_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!bclk_lvl && !bclk_tick));

endmodule

// File: rtl/aud_clkdiv_chain.sv
`timescale 1ns/1ps
// Audio master/bit clock divider chain, one chain per direction.
// Each direction selects a source tick, derives a master clock from it
// (divide, pass-through or pin), and divides that by F into a bit clock.
// Assumes all tick inputs are single-cycle pulses in the clk domain and
// that settings change only under reset; other changes restart a chain.
module aud_clkdiv_chain
    import acd_pkg::*;
#(
    parameter int NUM_DIR = 2,
    parameter int MOD_W   = 8,
    parameter int FIN_W   = 4,
    parameter int PSC_HI  = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            sys_tick,
    input  logic                            ext_tick,
    input  logic [NUM_DIR-1:0]              mck_pin_tick,
    input  logic [NUM_DIR-1:0]              cfg_mck_in,
    input  logic [NUM_DIR-1:0]              cfg_bypass,
    input  logic [NUM_DIR-1:0]              cfg_src_ext,
    input  logic [NUM_DIR-1:0]              cfg_psc8,
    input  logic [NUM_DIR-1:0][MOD_W-1:0]   cfg_mod_m1,
    input  logic [NUM_DIR-1:0][FIN_W-1:0]   cfg_fin_m1,
    output logic [NUM_DIR-1:0]              mck_tick,
    output logic [NUM_DIR-1:0]              mck_lvl,
    output logic [NUM_DIR-1:0]              bclk_tick,
    output logic [NUM_DIR-1:0]              bclk_lvl
);

    localparam int CFG_W = 4 + MOD_W + FIN_W;

    for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
        mck_mode_e        mode;
        logic             src_tick;
        logic             restart;
        logic             mck_tick_w;
        logic [CFG_W-1:0] cfg_vec;

        // All settings of this direction, gathered for change detection.
        assign cfg_vec = {cfg_mck_in[d], cfg_bypass[d], cfg_src_ext[d],
                          cfg_psc8[d], cfg_mod_m1[d], cfg_fin_m1[d]};

        acd_src_select u_src (
            .sys_tick (sys_tick),
            .ext_tick (ext_tick),
            .pin_tick (mck_pin_tick[d]),
            .mck_in   (cfg_mck_in[d]),
            .bypass   (cfg_bypass[d]),
            .src_ext  (cfg_src_ext[d]),
            .src_tick (src_tick),
            .mode     (mode)
        );

        acd_cfg_watch #(.CFG_W(CFG_W)) u_watch (
            .clk     (clk),
            .rst_n   (rst_n),
            .cfg     (cfg_vec),
            .restart (restart)
        );

        acd_mck_div #(.PSC_HI(PSC_HI), .MOD_W(MOD_W)) u_mck (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr      (restart),
            .src_tick (src_tick),
            .mode     (mode),
            .psc8     (cfg_psc8[d]),
            .mod_m1   (cfg_mod_m1[d]),
            .mck_tick (mck_tick_w),
            .mck_lvl  (mck_lvl[d])
        );

        acd_bclk_div #(.FIN_W(FIN_W)) u_bclk (
            .clk       (clk),
            .rst_n     (rst_n),
            .clr       (restart),
            .mck_tick  (mck_tick_w),
            .fin_m1    (cfg_fin_m1[d]),
            .bclk_tick (bclk_tick[d]),
            .bclk_lvl  (bclk_lvl[d])
        );

        assign mck_tick[d] = mck_tick_w;
    end

endmodule

// File: tb/test_aud_clkdiv_chain.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver models each requirement and queues the
// expected master ticks; the monitor pops and compares them as they appear.
module test_aud_clkdiv_chain;
    localparam int ND = 2;
    localparam int MW = 8;
    localparam int FW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sys_tick = 1'b0;
    logic ext_tick = 1'b0;
    logic [ND-1:0] pin_tick = '0;
    logic [ND-1:0] c_mck_in = '0;
    logic [ND-1:0] c_bypass = '0;
    logic [ND-1:0] c_src_ext = '0;
    logic [ND-1:0] c_psc8 = '0;
    logic [ND-1:0][MW-1:0] c_mod_m1 = '0;
    logic [ND-1:0][FW-1:0] c_fin_m1 = '0;
    logic [ND-1:0] mck_tick, mck_lvl, bclk_tick, bclk_lvl;

    aud_clkdiv_chain #(.NUM_DIR(ND), .MOD_W(MW), .FIN_W(FW), .PSC_HI(8)) i_aud_clkdiv_chain (
        .clk          (clk),
        .rst_n        (rst_n),
        .sys_tick     (sys_tick),
        .ext_tick     (ext_tick),
        .mck_pin_tick (pin_tick),
        .cfg_mck_in   (c_mck_in),
        .cfg_bypass   (c_bypass),
        .cfg_src_ext  (c_src_ext),
        .cfg_psc8     (c_psc8),
        .cfg_mod_m1   (c_mod_m1),
        .cfg_fin_m1   (c_fin_m1),
        .mck_tick     (mck_tick),
        .mck_lvl      (mck_lvl),
        .bclk_tick    (bclk_tick),
        .bclk_lvl     (bclk_lvl)
    );

    always #2 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int    cyc;
        bit    mlvl;
        bit    bt;
        bit    bl;
        string tag;
    } rec_t;

    rec_t  exp_q [ND][$];
    rec_t  mon_r;
    int    scnt [ND];
    int    mcnt [ND];
    bit    pend [ND];
    bit    pend_bt [ND];
    bit    pend_bl [ND];
    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 1'b0;
    bit    mon_on = 1'b0;
    string cur_tag = "R1";

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    task automatic set_cfg(input int d, input bit mi, input bit by, input bit ex,
                           input bit p8, input int m1, input int f1);
        c_mck_in[d]  = mi;
        c_bypass[d]  = by;
        c_src_ext[d] = ex;
        c_psc8[d]    = p8;
        c_mod_m1[d]  = MW'(m1);
        c_fin_m1[d]  = FW'(f1);
    endtask

    task automatic model_clear(input int d);
        scnt[d] = 0;
        mcnt[d] = 0;
        exp_q[d].delete();
    endtask

    // Expected master ticks from the requirements, sampled at the next edge.
    task automatic model_step(input int d, input bit s, input bit e, input bit p);
        bit   t;
        bit   pass;
        int   h, f, k, hi;
        rec_t r;
        t = c_mck_in[d] ? p : (c_src_ext[d] ? e : s);
        if (!t) return;
        scnt[d]++;
        pass = c_mck_in[d] || c_bypass[d];
        h = (c_psc8[d] ? 8 : 1) * (int'(c_mod_m1[d]) + 1);
        if (pass || (scnt[d] % (2 * h)) == h) begin
            f  = int'(c_fin_m1[d]) + 1;
            k  = mcnt[d] % f;
            hi = (f == 1) ? 1 : f / 2;
            r.cyc  = cyc + 1;
            r.mlvl = !pass;
            r.bt   = (k == 0);
            r.bl   = (k < hi);
            r.tag  = cur_tag;
            exp_q[d].push_back(r);
            mcnt[d]++;
        end
    endtask

    function automatic int exp_lvl(input int d);
        int h;
        if (c_mck_in[d] || c_bypass[d]) return 0;
        h = (c_psc8[d] ? 8 : 1) * (int'(c_mod_m1[d]) + 1);
        return ((scnt[d] % (2 * h)) >= h) ? 1 : 0;
    endfunction

    // Drive n cycles; each line ticks when the index is a multiple of its period.
    task automatic run(input int n, input int ps, input int pe, input int p0, input int p1);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            sys_tick    = (ps != 0) && (i % ps == 0);
            ext_tick    = (pe != 0) && (i % pe == 0);
            pin_tick[0] = (p0 != 0) && (i % p0 == 0);
            pin_tick[1] = (p1 != 0) && (i % p1 == 0);
            for (int d = 0; d < ND; d++) model_step(d, sys_tick, ext_tick, pin_tick[d]);
        end
        @(negedge clk);
        sys_tick = 1'b0;
        ext_tick = 1'b0;
        pin_tick = '0;
        repeat (4) @(negedge clk);
        for (int d = 0; d < ND; d++) begin
            chk(cur_tag, $sformatf("dir%0d master ticks still due", d), exp_q[d].size(), 0);
            chk(cur_tag, $sformatf("dir%0d mck_lvl after run", d), int'(mck_lvl[d]), exp_lvl(d));
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int d = 0; d < ND; d++) model_clear(d);
    endtask

    // Monitor: pops the scoreboard on every master tick, checks the bit clock after it.
    always @(negedge clk) begin
        if (mon_on) begin
            for (int d = 0; d < ND; d++) begin
                if (pend[d]) begin
                    chk("R6", $sformatf("dir%0d bclk_tick", d), int'(bclk_tick[d]), int'(pend_bt[d]));
                    chk("R7", $sformatf("dir%0d bclk_lvl", d), int'(bclk_lvl[d]), int'(pend_bl[d]));
                    pend[d] = 1'b0;
                end else if (bclk_tick[d]) begin
                    chk("R6", $sformatf("dir%0d bclk_tick without master tick", d), 1, 0);
                end
                if (mck_tick[d]) begin
                    if (exp_q[d].size() == 0) begin
                        chk(cur_tag, $sformatf("dir%0d unexpected mck_tick", d), 1, 0);
                    end else begin
                        mon_r = exp_q[d].pop_front();
                        chk(mon_r.tag, $sformatf("dir%0d mck_tick cycle", d), cyc, mon_r.cyc);
                        chk(mon_r.tag, $sformatf("dir%0d mck_lvl at tick", d), int'(mck_lvl[d]), int'(mon_r.mlvl));
                        pend[d]    = 1'b1;
                        pend_bt[d] = mon_r.bt;
                        pend_bl[d] = mon_r.bl;
                    end
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog (any requirement): actual still running expected finished");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: outputs low in reset despite ticks on every line, and just after.
        set_cfg(0, 0, 0, 0, 0, 0, 0);
        set_cfg(1, 0, 1, 0, 0, 0, 0);
        sys_tick = 1'b1;
        ext_tick = 1'b1;
        pin_tick = '1;
        repeat (5) @(negedge clk);
        for (int d = 0; d < ND; d++) begin
            chk("R1", $sformatf("dir%0d outputs in reset", d),
                int'({mck_tick[d], mck_lvl[d], bclk_tick[d], bclk_lvl[d]}), 0);
        end
        rst_n    = 1'b1;
        sys_tick = 1'b0;
        ext_tick = 1'b0;
        pin_tick = '0;
        @(negedge clk);
        for (int d = 0; d < ND; d++) begin
            chk("R1", $sformatf("dir%0d outputs after release", d),
                int'({mck_tick[d], mck_lvl[d], bclk_tick[d], bclk_lvl[d]}), 0);
            model_clear(d);
        end
        mon_on = 1'b1;

        // R2: P=1, M=1 (F=2) and P=1, M=3 (F=3); dense then sparse ticks.
        set_cfg(0, 0, 0, 0, 0, 0, 1);
        set_cfg(1, 0, 0, 0, 0, 2, 2);
        do_reset();
        cur_tag = "R2";
        run(40, 1, 0, 0, 0);
        run(30, 3, 0, 0, 0);

        // R2: prescaler 8 with M=2 (F=1), and the full 8*256 half period (F=16).
        set_cfg(0, 0, 0, 0, 1, 1, 0);
        set_cfg(1, 0, 0, 0, 1, 255, 15);
        do_reset();
        cur_tag = "R2";
        run(4200, 1, 0, 0, 0);

        // R3: dir0 uses the external oscillator, dir1 the system clock.
        set_cfg(0, 0, 0, 1, 0, 1, 1);
        set_cfg(1, 0, 0, 0, 0, 1, 1);
        do_reset();
        cur_tag = "R3";
        run(60, 3, 2, 0, 0);

        // R4: pass-through ignores P and M; pins carry noise.
        set_cfg(0, 0, 1, 0, 1, 7, 2);
        set_cfg(1, 0, 1, 1, 0, 0, 0);
        do_reset();
        cur_tag = "R4";
        run(30, 1, 3, 1, 1);

        // R5: pin mode overrides pass-through and both source lines.
        set_cfg(0, 1, 1, 0, 0, 0, 1);
        set_cfg(1, 1, 0, 1, 1, 3, 4);
        do_reset();
        cur_tag = "R5";
        run(40, 1, 1, 2, 1);

        // R8: same P and M with F=7 and F=4 give the same master timing.
        set_cfg(0, 0, 0, 0, 0, 1, 6);
        set_cfg(1, 0, 0, 0, 0, 1, 3);
        do_reset();
        cur_tag = "R8";
        run(80, 2, 0, 0, 0);

        // R9 and R10: restart dir0 mid-count while dir1 keeps running.
        set_cfg(0, 0, 0, 0, 0, 0, 3);
        set_cfg(1, 0, 0, 0, 0, 0, 3);
        do_reset();
        cur_tag = "R9";
        run(1, 1, 0, 0, 0);
        @(negedge clk);
        set_cfg(0, 0, 0, 0, 0, 2, 3);
        model_clear(0);
        @(negedge clk);
        chk("R9", "dir0 outputs after restart",
            int'({mck_tick[0], mck_lvl[0], bclk_tick[0], bclk_lvl[0]}), 0);
        chk("R10", "dir1 mck_lvl across dir0 restart", int'(mck_lvl[1]), 1);
        chk("R10", "dir1 bclk_lvl across dir0 restart", int'(bclk_lvl[1]), 1);
        cur_tag = "R9";
        run(6, 1, 0, 0, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule